// File: doc/BRIEF.md
# Indexed Register Bus Controller

This block is the pin-level engine between an internal arbiter and an external Ethernet MAC chip. That chip exposes its registers through an indexed bus: one active-low chip select, a command line that marks each transfer as an index or a data transfer, active-low read and write strobes, and a single 16-bit data bus that carries traffic in both directions. The controller splits this shared bus into a driven value, an output enable and an input, so a pad-level tristate buffer can sit outside it.

An arbiter hands over one access at a time on a valid/ready request channel. A request carries the kind of access, the register index, the write data and a continue flag. A full access first writes the index, then waits out a quiet gap, and then either writes data or strobes a read. A continued read skips the index phase, because the chip advances its own read pointer after every read. The block reports completion with a one-cycle done pulse. Read data is valid on that same cycle.

The request channel follows these back-pressure rules. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Ready stays low from the next cycle until the access has finished. The request fields are captured at acceptance, so they may change freely afterwards. Nothing about the access is buffered beyond that single capture.

Top module: `idx_bus_ctrl`

## Requirements
- R1: During reset and in the first idle cycle after it, chip select, write strobe and read strobe are high, the output enable is low, done is low and ready is high.
- R2: A request is accepted only on an edge where valid and ready are both high. Ready is low on the following cycle. The index, write data, kind and continue flag are captured at that edge, and later changes to these inputs have no effect on the access in progress.
- R3: A full access starts with an index phase. Chip select is low, the command line is 0, and the index is driven zero-extended onto the data bus. The output enable is high for one cycle before the write strobe, for STROBE_CYC cycles with the write strobe low, and for one cycle after the strobe rises, with the driven value stable throughout.
- R4: Between the end of the index phase and the start of the data phase, there are at least GAP_CYC cycles with chip select low, both strobes high and the output enable low.
- R5: A write access (`req_write`=1) finishes with a data phase. The command line is 1 and the captured write data is driven, with the same one-cycle setup, STROBE_CYC-cycle strobe and one-cycle hold as the index phase.
- R6: A read access (`req_write`=0) finishes with the read strobe low for STROBE_CYC cycles, the command line at 1 and the output enable low. The data bus is sampled on the last strobe cycle. The two strobes are never low together.
- R7: A read with `req_cont`=1 skips the index phase. It drives chip select low for GAP_CYC quiet cycles and then strobes a read, so it returns the register after the one read last.
- R8: The output enable is never high while the read strobe is low, and never high while chip select is high.
- R9: Done is a one-cycle pulse on the cycle where chip select returns high, and read data is valid on that cycle. Counted from the cycle after acceptance as cycle 1, done falls on cycle 5+2*STROBE_CYC+GAP_CYC for a write, 3+2*STROBE_CYC+GAP_CYC for a full read, and 1+STROBE_CYC+GAP_CYC for a continued read.
- R10: The continue flag is ignored for writes, which always perform the full index and data sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_cont | input | 1 | Continued read: skip the index phase |
| req_index | input | IDX_W | Register index |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with done |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_cmd | output | 1 | Command line: 0 index, 1 data |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dout | output | DATA_W | Value to drive on the shared data bus |
| bus_oe | output | 1 | Output enable for the data bus driver |
| bus_din | input | DATA_W | Value received from the shared data bus |

## Verification
With the default strobe length of 2 and gap of 2, the done pulse is due 11 cycles after acceptance for a write, 9 for a full read and 5 for a continued read. Ready must already be low 1 cycle after acceptance. The bench counts falling edges from the accepting edge and compares the cycle where done appears with these figures. It samples done, chip select and read data on that cycle, then confirms one cycle later that done has dropped and ready is back. A chip model in the bench commits index and data writes when the write strobe rises, and advances its read pointer when the read strobe rises. Read results are therefore compared against a shadow register file kept purely from the issued requests. Monitors in the bench also record the shortest quiet gap before each data phase and any cycle where the driver and a read overlap.

// File: rtl/idx_bus_pkg.sv
package idx_bus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IX_SETUP,
    ST_IX_STROBE,
    ST_IX_HOLD,
    ST_QUIET,
    ST_WD_SETUP,
    ST_WD_STROBE,
    ST_WD_HOLD,
    ST_RD_STROBE,
    ST_FINISH
  } ibus_state_e;

  typedef struct packed {
    logic is_write;
    logic is_cont;
  } ibus_kind_t;
endpackage

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
  import idx_bus_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cont,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output ibus_state_e       state,
  output logic [IDX_W-1:0]  lat_index,
  output logic [DATA_W-1:0] lat_wdata
);
  localparam int LONGEST = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1) + 1;

  ibus_state_e      nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  ibus_kind_t       kind;
  logic             take;

  function automatic logic [CNT_W-1:0] span(ibus_state_e s);
    case (s)
      ST_IX_STROBE, ST_WD_STROBE, ST_RD_STROBE: span = CNT_W'(STROBE_CYC - 1);
      ST_QUIET:                                 span = CNT_W'(GAP_CYC - 1);
      default:                                  span = '0;
    endcase
  endfunction

  assign take      = req_valid && (state == ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign rsp_done  = (state == ST_FINISH);

  always_comb begin
    nxt     = state;
    nxt_cnt = (cnt == '0) ? '0 : cnt - 1'b1;
    case (state)
      ST_IDLE:      if (take) nxt = (req_cont && !req_write) ? ST_QUIET : ST_IX_SETUP;
      ST_IX_SETUP:  nxt = ST_IX_STROBE;
      ST_IX_STROBE: if (cnt == '0) nxt = ST_IX_HOLD;
      ST_IX_HOLD:   nxt = ST_QUIET;
      ST_QUIET:     if (cnt == '0) nxt = kind.is_write ? ST_WD_SETUP : ST_RD_STROBE;
      ST_WD_SETUP:  nxt = ST_WD_STROBE;
      ST_WD_STROBE: if (cnt == '0) nxt = ST_WD_HOLD;
      ST_WD_HOLD:   nxt = ST_FINISH;
      ST_RD_STROBE: if (cnt == '0) nxt = ST_FINISH;
      ST_FINISH:    nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
    if (nxt != state) nxt_cnt = span(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      kind      <= '0;
      lat_index <= '0;
      lat_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      state <= nxt;
      cnt   <= nxt_cnt;
      if (take) begin
        kind.is_write <= req_write;
        kind.is_cont  <= req_cont && !req_write;
        lat_index     <= req_index;
        lat_wdata     <= req_wdata;
      end
      if (state == ST_RD_STROBE && cnt == '0) rsp_rdata <= bus_din;
    end
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  assert_write_keeps_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUIET && kind.is_write) |-> !kind.is_cont);
endmodule

// File: rtl/idx_bus_pins.sv
module idx_bus_pins
  import idx_bus_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ibus_state_e       state,
  input  logic [IDX_W-1:0]  lat_index,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              bus_cs_n,
  output logic              bus_cmd,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);
  logic in_ix, in_wd;

  assign in_ix = (state == ST_IX_SETUP) || (state == ST_IX_STROBE) || (state == ST_IX_HOLD);
  assign in_wd = (state == ST_WD_SETUP) || (state == ST_WD_STROBE) || (state == ST_WD_HOLD);

  always_comb begin
    bus_cs_n = (state == ST_IDLE) || (state == ST_FINISH);
    bus_cmd  = !in_ix;
    bus_wr_n = !((state == ST_IX_STROBE) || (state == ST_WD_STROBE));
    bus_rd_n = (state != ST_RD_STROBE);
    bus_oe   = in_ix || in_wd;
    if (in_ix)      bus_dout = DATA_W'(lat_index);
    else if (in_wd) bus_dout = lat_wdata;
    else            bus_dout = '0;
  end

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !bus_rd_n));
  assert_oe_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_cs_n);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  assert_hold_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_oe && $stable(bus_dout) && $stable(bus_cmd)));
  assert_setup_before_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> ($past(bus_oe) && $stable(bus_dout)));
endmodule

// File: rtl/idx_bus_ctrl.sv
module idx_bus_ctrl
  import idx_bus_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cont,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_cmd,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int RUN_W = $clog2(GAP_CYC + 2) + 1;

  ibus_state_e       state;
  logic [IDX_W-1:0]  lat_index;
  logic [DATA_W-1:0] lat_wdata;

  idx_bus_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cont(req_cont), .req_index(req_index), .req_wdata(req_wdata),
    .bus_din(bus_din), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .state(state), .lat_index(lat_index), .lat_wdata(lat_wdata)
  );

  idx_bus_pins #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .lat_index(lat_index),
    .lat_wdata(lat_wdata), .bus_cs_n(bus_cs_n), .bus_cmd(bus_cmd),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  // Quiet-cycle run length, used to check the gap ahead of each data phase.
  logic [RUN_W-1:0] quiet_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_run <= '0;
    else if (bus_oe || !bus_wr_n || !bus_rd_n) quiet_run <= '0;
    else if (quiet_run != {RUN_W{1'b1}}) quiet_run <= quiet_run + 1'b1;
  end

  assert_gap_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> (32'(quiet_run) >= GAP_CYC));
  assert_gap_before_wdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_oe) && bus_cmd) |-> (32'(quiet_run) >= GAP_CYC));
  assert_done_with_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_done);
endmodule

// File: tb/sim_idx_bus_ctrl.sv
module sim_idx_bus_ctrl;
  localparam int IW = 8, DW = 16, SC = 2, GC = 2;
  localparam int LAT_WR = 5 + 2*SC + GC;
  localparam int LAT_RD = 3 + 2*SC + GC;
  localparam int LAT_CT = 1 + SC + GC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cont = 1'b0;
  logic [IW-1:0] req_index = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, bus_cs_n, bus_cmd, bus_wr_n, bus_rd_n, bus_oe;
  logic [DW-1:0] rsp_rdata, bus_dout, bus_din;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  idx_bus_ctrl #(.IDX_W(IW), .DATA_W(DW), .STROBE_CYC(SC), .GAP_CYC(GC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cont(req_cont), .req_index(req_index),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_cmd(bus_cmd), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  // Chip model: index/data commit on write strobe release, pointer advance on read strobe release.
  logic [DW-1:0] chip_reg [256];
  logic [7:0]    chip_ptr;
  logic          prev_wr, prev_rd, prev_oe;
  int            quiet, min_gap, clash;

  function automatic logic [DW-1:0] seed_val(int i);
    return DW'(i * 16'h0101) ^ 16'h5A5A;
  endfunction

  assign bus_din = (!bus_cs_n && !bus_rd_n) ? chip_reg[chip_ptr] : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) chip_reg[i] <= seed_val(i);
      chip_ptr <= '0; prev_wr <= 1'b1; prev_rd <= 1'b1; prev_oe <= 1'b0;
      quiet <= 0; min_gap <= 1000; clash <= 0;
    end else begin
      prev_wr <= bus_wr_n; prev_rd <= bus_rd_n; prev_oe <= bus_oe;
      if (!prev_wr && bus_wr_n && !bus_cs_n) begin
        if (!bus_cmd) chip_ptr <= bus_dout[7:0];
        else chip_reg[chip_ptr] <= bus_dout;
      end
      if (!prev_rd && bus_rd_n) chip_ptr <= chip_ptr + 8'd1;
      if (bus_oe || !bus_wr_n || !bus_rd_n) quiet <= 0; else quiet <= quiet + 1;
      if (((!prev_oe && bus_oe && bus_cmd) || (prev_rd && !bus_rd_n)) && quiet < min_gap)
        min_gap <= quiet;
      if (bus_oe && (!bus_rd_n || bus_cs_n)) clash <= clash + 1;
    end
  end

  // Shadow of the register file, kept from issued requests only.
  logic [DW-1:0] shadow [256];
  logic [7:0]    sh_ptr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit cont, input logic [IW-1:0] idx, input logic [DW-1:0] wd);
    int lat;
    logic [DW-1:0] expv;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cont = cont; req_index = idx; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = ~wr; req_cont = ~cont; req_index = IW'($urandom); req_wdata = DW'($urandom);
    chk(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
    lat = 1;
    while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
    if (wr) begin
      chk(lat == LAT_WR, cont ? "R10 write latency with cont" : "R9 write latency", lat, LAT_WR);
      shadow[idx] = wd; sh_ptr = idx;
    end else begin
      if (!cont) sh_ptr = idx;
      expv = shadow[sh_ptr];
      chk(lat == (cont ? LAT_CT : LAT_RD), cont ? "R7 cont read latency" : "R9 read latency",
          lat, cont ? LAT_CT : LAT_RD);
      chk(rsp_rdata == expv, cont ? "R7 cont read data" : "R6 read data", rsp_rdata, expv);
      sh_ptr = sh_ptr + 8'd1;
    end
    chk(bus_cs_n == 1'b1, "R9 cs high with done", 32'(bus_cs_n), 1);
    @(negedge clk);
    chk(!rsp_done && req_ready, "R9 done single cycle", {rsp_done, req_ready}, 1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_0042));
    for (int i = 0; i < 256; i++) shadow[i] = seed_val(i);
    sh_ptr = '0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe && !rsp_done && req_ready,
        "R1 reset outputs", {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe, rsp_done, req_ready}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && !bus_oe && req_ready, "R1 idle after reset", {bus_cs_n, bus_oe, req_ready}, 3'b101);

    access(1'b0, 1'b0, 8'd7, '0);          // R6 full read of seeded register
    access(1'b0, 1'b1, 8'd0, '0);          // R7 continued read of index 8
    access(1'b1, 1'b1, 8'd3, 16'h1234);    // R10 cont flag on a write, R3 R5
    access(1'b0, 1'b0, 8'd3, '0);          // R4 R6 read back
    access(1'b1, 1'b0, 8'd255, 16'hFFFF);  // top index
    access(1'b1, 1'b0, 8'd0, 16'h0000);    // bottom index, zero data
    access(1'b0, 1'b0, 8'd255, '0);
    access(1'b0, 1'b1, 8'd0, '0);          // R7 pointer wraps to 0
    access(1'b0, 1'b1, 8'd0, '0);

    for (int n = 0; n < 80; n++) begin
      bit wr, ct;
      wr = ($urandom % 3) == 0;
      ct = ($urandom % 2) == 0;
      access(wr, ct, IW'($urandom % 16), DW'($urandom));
    end

    chk(min_gap >= GC, "R4 quiet gap before data phase", min_gap, GC);
    chk(clash == 0, "R8 no driver overlap", clash, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule